// File: doc/BRIEF.md
# Lockable Low-Memory Window Guard

This block holds one byte of configuration state that controls access to a fixed range of low memory. After reset the range behaves as ordinary RAM: every memory request passes unchanged to the RAM port. Software unlocks the feature with a short handshake. A write of 0xFF arms the register. Once it is armed, a write of 0x02 closes the range.

When the range is closed, the block sinks every memory request whose address falls inside it. A read returns 0xFF in the same cycle and a write never reaches RAM. Requests outside the range keep passing through. The register can no longer be changed, and only a reset reopens the range. Because the reset does not touch RAM, data written before the range was closed can be read again afterwards.

The range base and length are parameters. The address match is combinational, so the memory path adds no wait state.

Top module: `lockwin_guard`

## Requirements
- R1: After reset the register reads 0x00. Every memory request, inside the range or outside it, is forwarded to RAM with the same address, write flag and data. Read data comes back from RAM unchanged.
- R2: In the idle state (reads 0x00), a register write of any value from 0x00 to 0xFE leaves the register reading 0x00.
- R3: In the idle state, a register write of 0xFF moves the block to the armed state, which reads 0x01.
- R4: In the armed state, a write of 0x02 moves the block to the closed state, which reads 0x02. Any other value, 0xFF included, leaves it reading 0x01.
- R5: In the closed state, register writes of every value from 0x00 to 0xFF leave the register reading 0x02.
- R6: In the closed state, a request with WIN_BASE <= address < WIN_BASE+WIN_LEN is not forwarded (ram_req low). Its read data is 0xFF in the same cycle, and its write has no effect on RAM.
- R7: In the closed state, addresses just below WIN_BASE and at or above WIN_BASE+WIN_LEN still pass through to RAM.
- R8: Reset returns the register to 0x00 and reopens the range. RAM contents written before the range was closed become readable again.
- R9: A register write takes effect at the next clock edge. A register read returns the current state in the same cycle. A memory request in the same cycle as the closing write is still handled under the old, open state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write value |
| cfg_rdata | output | 8 | Register read value (current state) |
| mem_req | input | 1 | Memory request valid |
| mem_we | input | 1 | Memory request is a write |
| mem_addr | input | ADDR_W | Memory request byte address |
| mem_wdata | input | 8 | Memory write data |
| mem_rdata | output | 8 | Memory read data to requester |
| ram_req | output | 1 | Forwarded request valid |
| ram_we | output | 1 | Forwarded write flag |
| ram_addr | output | ADDR_W | Forwarded address |
| ram_wdata | output | 8 | Forwarded write data |
| ram_rdata | input | 8 | Read data from RAM |

## Verification
Two events can land in the same cycle: the register write that closes the range, and a memory access inside that range. The bench provokes this with a directed step. It drives the 0x02 write and a write of 0x5A inside the range in the same cycle, and checks that the access is still forwarded. It then checks that a read of the same byte one cycle later returns 0xFF, and that the byte reads 0x5A again after reset. Random steps also mix register writes and memory requests in the same cycle, and each one is judged against the state the bench model held before that edge.

// File: rtl/lockwin_guard.sv
module lockwin_guard #(
  parameter int          ADDR_W   = 24,
  parameter logic [31:0] WIN_BASE = 32'h0003_0000,
  parameter logic [31:0] WIN_LEN  = 32'h0002_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              mem_req,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_wdata,
  output logic [7:0]        mem_rdata,
  output logic              ram_req,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata
);

  localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(WIN_BASE);
  localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(WIN_BASE + WIN_LEN);
  localparam logic [7:0] KEY_ARM   = 8'hFF;
  localparam logic [7:0] KEY_CLOSE = 8'h02;

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_ARMED = 2'd1, S_CLOSED = 2'd2} st_t;

  st_t st, st_nx;

  always_comb begin
    st_nx = st;
    if (cfg_we) begin
      unique case (st)
        S_IDLE:   if (cfg_wdata == KEY_ARM)   st_nx = S_ARMED;
        S_ARMED:  if (cfg_wdata == KEY_CLOSE) st_nx = S_CLOSED;
        default:  st_nx = st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= S_IDLE;
    else        st <= st_nx;

  assign cfg_rdata = {6'd0, st};

  wire in_win  = ({1'b0, mem_addr} >= LO) && ({1'b0, mem_addr} < HI);
  wire blocked = (st == S_CLOSED) && in_win;

  assign ram_req   = mem_req && !blocked;
  assign ram_we    = mem_we;
  assign ram_addr  = mem_addr;
  assign ram_wdata = mem_wdata;
  assign mem_rdata = blocked ? 8'hFF : ram_rdata;

  AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> cfg_rdata == 8'h00); // R1
  AST_OPEN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata != 8'h02 && mem_req) |-> (ram_req && ram_addr == mem_addr && mem_rdata == ram_rdata)); // R1
  AST_IDLE_JUNK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata == 8'h00 && cfg_we && cfg_wdata != 8'hFF) |=> cfg_rdata == 8'h00); // R2
  AST_IDLE_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata == 8'h00 && cfg_we && cfg_wdata == 8'hFF) |=> cfg_rdata == 8'h01); // R3
  AST_ARMED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata == 8'h01 && !(cfg_we && cfg_wdata == 8'h02)) |=> cfg_rdata == 8'h01); // R4
  AST_ARMED_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata == 8'h01 && cfg_we && cfg_wdata == 8'h02) |=> cfg_rdata == 8'h02); // R4
  AST_CLOSED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata == 8'h02 |=> cfg_rdata == 8'h02); // R5
  AST_SINK_NO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata == 8'h02 && mem_req && {1'b0, mem_addr} >= LO && {1'b0, mem_addr} < HI)
      |-> (!ram_req && mem_rdata == 8'hFF)); // R6
  AST_OUTSIDE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && ({1'b0, mem_addr} < LO || {1'b0, mem_addr} >= HI)) |-> ram_req); // R7
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata inside {8'h00, 8'h01, 8'h02}); // R9

endmodule

// File: tb/tb_lockwin_guard.sv
`timescale 1ns/1ps
module tb_lockwin_guard;
  localparam int ADDR_W = 24;
  localparam int BASE = 32'h0003_0000;
  localparam int LEN  = 32'h0002_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'd0;
  logic [7:0] cfg_rdata;
  logic mem_req = 1'b0, mem_we = 1'b0;
  logic [ADDR_W-1:0] mem_addr = '0;
  logic [7:0] mem_wdata = 8'd0;
  logic [7:0] mem_rdata;
  logic ram_req, ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [7:0] ram_wdata, ram_rdata;

  always #2.5 clk = ~clk;

  lockwin_guard #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .ram_req(ram_req), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata));

  logic [7:0] ram_m [int unsigned];
  logic [7:0] shadow [int unsigned];
  int unsigned wcnt = 0;

  function automatic logic [7:0] ram_rd(input logic [ADDR_W-1:0] a, input int unsigned c);
    int unsigned k = int'(a);
    if (c == 32'hFFFF_FFFF) return 8'h00;
    return ram_m.exists(k) ? ram_m[k] : 8'h00;
  endfunction
  assign ram_rdata = ram_rd(ram_addr, wcnt);

  always @(posedge clk)
    if (ram_req && ram_we) begin
      ram_m[int'(ram_addr)] = ram_wdata;
      wcnt = wcnt + 1;
    end

  int checks = 0, errors = 0;
  logic [7:0] exp_st = 8'h00;
  bit done = 0;

  function automatic bit in_win(input int unsigned a);
    return (a >= BASE) && (a < BASE + LEN);
  endfunction
  function automatic logic [7:0] nxt(input logic [7:0] s, input logic [7:0] v);
    if (s == 8'h00 && v == 8'hFF) return 8'h01;
    if (s == 8'h01 && v == 8'h02) return 8'h02;
    return s;
  endfunction
  function automatic logic [7:0] sh(input int unsigned a);
    return shadow.exists(a) ? shadow[a] : 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_reg(input string tag);
    @(negedge clk); #1;
    chk(tag, {24'd0, cfg_rdata}, {24'd0, exp_st});
  endtask

  task automatic op(input string tag, input bit ce, input logic [7:0] cv,
                    input bit me, input bit we, input int unsigned a, input logic [7:0] d);
    bit blk;
    @(negedge clk);
    cfg_we = ce; cfg_wdata = cv;
    mem_req = me; mem_we = we; mem_addr = a[ADDR_W-1:0]; mem_wdata = d;
    #1;
    blk = (exp_st == 8'h02) && in_win(a);
    chk({tag, " cfg"}, {24'd0, cfg_rdata}, {24'd0, exp_st});
    if (me) begin
      chk({tag, " fwd"}, {31'd0, ram_req}, {31'd0, !blk});
      if (!we) chk({tag, " rd"}, {24'd0, mem_rdata}, {24'd0, blk ? 8'hFF : sh(a)});
    end
    @(posedge clk);
    if (me && we && !blk) shadow[a] = d;
    if (ce) exp_st = nxt(exp_st, cv);
    #1;
    cfg_we = 0; mem_req = 0; mem_we = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    exp_st = 8'h00;
    rst_n = 1;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk_reg("R1 reset");
    op("R1", 0, 0, 1, 1, BASE, 8'h32);
    op("R1", 0, 0, 1, 1, BASE + 16, 8'h5A);
    op("R1", 0, 0, 1, 0, BASE, 0);
    op("R1", 0, 0, 1, 0, BASE + LEN - 1, 0);
    for (int v = 0; v < 255; v++) begin
      op("R2", 1, v[7:0], 0, 0, 0, 0);
      chk_reg("R2 junk");
    end
    op("R3", 1, 8'hFF, 0, 0, 0, 0);
    chk_reg("R3 armed");
    op("R4", 1, 8'h00, 0, 0, 0, 0); chk_reg("R4 hold00");
    op("R4", 1, 8'hFF, 0, 0, 0, 0); chk_reg("R4 holdFF");
    op("R4", 1, 8'h03, 0, 0, 0, 0); chk_reg("R4 hold03");
    op("R9 same-cycle close", 1, 8'h02, 1, 1, BASE + 16, 8'h5A);
    chk_reg("R4 closed");
    op("R9 after close", 0, 0, 1, 0, BASE + 16, 0);
    op("R6", 0, 0, 1, 0, BASE, 0);
    op("R6", 0, 0, 1, 0, BASE + LEN - 1, 0);
    op("R6", 0, 0, 1, 1, BASE, 8'h77);
    op("R6", 0, 0, 1, 0, BASE, 0);
    op("R7", 0, 0, 1, 1, BASE - 1, 8'h11);
    op("R7", 0, 0, 1, 0, BASE - 1, 0);
    op("R7", 0, 0, 1, 1, BASE + LEN, 8'h22);
    op("R7", 0, 0, 1, 0, BASE + LEN, 0);
    for (int v = 0; v < 256; v++) begin
      op("R5", 1, v[7:0], (v % 4) == 0, (v % 8) == 0, BASE + v, 8'hC3);
      chk_reg("R5 immutable");
    end
    do_reset();
    chk_reg("R8 reg");
    op("R8", 0, 0, 1, 0, BASE, 0);
    chk("R8 old data", {24'd0, sh(BASE)}, 32'h32);
    op("R8", 0, 0, 1, 0, BASE + 16, 0);
    op("R8", 0, 0, 1, 1, BASE, 8'h23);
    op("R8", 0, 0, 1, 0, BASE, 0);
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom_range(0, 99);
      int unsigned a;
      logic [7:0] cv;
      case ($urandom_range(0, 3))
        0: a = BASE - 8 + $urandom_range(0, 15);
        1: a = BASE + LEN - 8 + $urandom_range(0, 15);
        2: a = BASE + $urandom_range(0, 63);
        default: a = $urandom_range(0, 32'h00FF_FFFF);
      endcase
      cv = (r < 15) ? 8'hFF : (r < 30) ? 8'h02 : 8'($urandom_range(0, 255));
      if (r == 99) do_reset();
      op(in_win(a) ? "R6 rand" : "R7 rand", $urandom_range(0, 2) == 0, cv,
         1, $urandom_range(0, 1) == 1, a, 8'($urandom_range(0, 255)));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule